// File: doc/BRIEF.md
# Fixed-Constant Adder with Specialised Lookahead

This block adds the fixed constant 0x1C7 (binary 000_111_000_111) to a 12-bit input. It returns the 12-bit sum and a carry-out. It is purely combinational, so it has no clock, no reset and no registers. It is meant to sit inside a datapath wherever one operand of an addition never changes.

The input is split into four 3-bit groups.

- Where the constant field is all zeros, the group is an incrementer chain. In each cell the generate term is 0, the propagate term is the input bit, and the sum bit is the input bit XOR the carry.
- Where the constant field is all ones, the group adds 7. In each cell the propagate term is 1, the generate term is the input bit, and the sum bit is the input bit XNOR the carry.

Each group reports a group propagate and a group generate. A second-level lookahead turns these into the group carries. It uses the standard lookahead equations, which shrink to a few gates once the constant terms are substituted. The design uses only AND, OR, XOR and XNOR logic and no arithmetic operator.

Top module: `fixed_const_adder`

## Requirements
- R1: For every 12-bit input value `a_in`, `sum_out` equals (`a_in` + 0x1C7) mod 4096.
- R2: For every input value, `carry_out` equals bit 12 of the full 13-bit sum `a_in` + 0x1C7.
- R3: Bits [2:0] and [8:6] form groups that add 7 plus their incoming carry, modulo 8. Bits [5:3] and [11:9] form groups that add only their incoming carry, modulo 8.
- R4: The carry into bits [5:3] is the OR of `a_in`[2:0], because the overall carry-in is 0.
- R5: The carry into bits [8:6] is the carry into bits [5:3] ANDed with all of `a_in`[5:3].
- R6: The carry into bits [11:9] is the OR of `a_in`[8:6] with the carry into bits [8:6].
- R7: `carry_out` is the AND of all of `a_in`[11:9] with the carry into bits [11:9].
- R8: The overall carry-in is 0, so an input of 0x000 gives `sum_out` = 0x1C7 and `carry_out` = 0.
- R9: An input of 0xFFF gives `sum_out` = 0x1C6 and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 12 | Operand to which the constant is added |
| sum_out | output | 12 | Low 12 bits of the sum |
| carry_out | output | 1 | Carry out of bit 11 |

## Verification
Immediate assertions are checked whenever the inputs change:
- The whole sum and carry-out are compared against an arithmetic reference.
- Each group's local sum is compared against its add-0 or add-7 rule.
- The four lookahead carries are compared against their reduced equations.

The group carries are not visible at the ports. Only the bench's scenarios show that they match R4 to R7 at the pins. The bench recovers each incoming carry from the difference between the result field and the operand field, and it sweeps every one of the 4096 input values.

// File: rtl/fca_pkg.sv
// Package: shared geometry of the fixed-constant adder.
// Assumes the constant is made of whole groups of all-ones or all-zeros.
package fca_pkg;
    localparam int FCA_GRP_W   = 3;
    localparam int FCA_NUM_GRP = 4;
    // One bit per group: 1 means the constant field of that group is all ones.
    localparam logic [FCA_NUM_GRP-1:0] FCA_ONES_MASK = 4'b0101;

    // Expand a per-group mask into the full-width constant operand.
    function automatic logic [FCA_GRP_W*FCA_NUM_GRP-1:0] fca_const(
        input logic [FCA_NUM_GRP-1:0] mask);
        logic [FCA_GRP_W*FCA_NUM_GRP-1:0] v;
        v = '0;
        for (int k = 0; k < FCA_NUM_GRP; k++) begin
            for (int b = 0; b < FCA_GRP_W; b++) begin
                v[k*FCA_GRP_W+b] = mask[k];
            end
        end
        return v;
    endfunction
endpackage

// File: rtl/fca_inc_group.sv
// Module: incrementer group. It adds only the incoming carry to its field.
// The per-cell generate is 0 and the propagate is the input bit.
// The group generate is therefore 0 and the group propagate is the AND of the inputs.
module fca_inc_group #(
    parameter int GW = 3
) (
    input  logic [GW-1:0] x,
    input  logic          cin,
    output logic [GW-1:0] s,
    output logic          grp_p,
    output logic          grp_g
);
    logic [GW-1:0] c;

    // Local carries: each is the carry-in ANDed with all lower input bits.
    always_comb begin
        logic run;
        run = cin;
        for (int i = 0; i < GW; i++) begin
            c[i] = run;
            run  = run & x[i];
        end
    end

    // Sum bits and group terms.
    always_comb begin
        s     = x ^ c;
        grp_p = &x;
        grp_g = 1'b0;
    end

    // R3: the field adds only its carry-in, modulo 2**GW.
    always_comb begin
        assert_inc_group_R3: assert (s == GW'(x + GW'(cin)))
            else $error("inc group sum mismatch");
    end
endmodule

// File: rtl/fca_dec_group.sv
// Module: add-all-ones group (it adds 2**GW-1 plus its carry-in).
// The per-cell propagate is 1 and the generate is the input bit.
// The group propagate is therefore 1 and the group generate is the OR of the inputs.
module fca_dec_group #(
    parameter int GW = 3
) (
    input  logic [GW-1:0] x,
    input  logic          cin,
    output logic [GW-1:0] s,
    output logic          grp_p,
    output logic          grp_g
);
    logic [GW-1:0] c;

    // Local carries: each is the carry-in ORed with all lower input bits.
    always_comb begin
        logic run;
        run = cin;
        for (int i = 0; i < GW; i++) begin
            c[i] = run;
            run  = run | x[i];
        end
    end

    // Sum bits (XNOR of input and carry) and group terms.
    always_comb begin
        s     = ~(x ^ c);
        grp_p = 1'b1;
        grp_g = |x;
    end

    // R3: the field adds all ones plus its carry-in, modulo 2**GW.
    always_comb begin
        assert_dec_group_R3: assert (s == GW'(x + {GW{1'b1}} + GW'(cin)))
            else $error("dec group sum mismatch");
    end
endmodule

// File: rtl/fca_lookahead.sv
// Module: second-level carry lookahead over NG group (P, G) pairs.
// Each carry is built in flat sum-of-products form from the group terms.
// The groups tie their constant terms to fixed levels, so the logic collapses.
module fca_lookahead #(
    parameter int NG = 4,
    parameter logic [NG-1:0] ONES_MASK = 4'b0101
) (
    input  logic          cin,
    input  logic [NG-1:0] grp_p,
    input  logic [NG-1:0] grp_g,
    output logic [NG:0]   carry
);
    // Flat lookahead: carry[k] = OR over j<k of (G_j AND P_j+1..P_k-1), plus cin AND P_0..P_k-1.
    always_comb begin
        carry[0] = cin;
        for (int k = 1; k <= NG; k++) begin
            logic acc;
            logic t;
            t = cin;
            for (int m = 0; m < k; m++) t = t & grp_p[m];
            acc = t;
            for (int j = 0; j < k; j++) begin
                t = grp_g[j];
                for (int m = j + 1; m < k; m++) t = t & grp_p[m];
                acc = acc | t;
            end
            carry[k] = acc;
        end
    end

    // Check the reduced equations when the default geometry is in use.
    generate
        if (NG == 4 && ONES_MASK == 4'b0101) begin : g_reduced_chk
            // Compare each flat carry with its reduced form.
            always_comb begin
                assert_c3_R4: assert (carry[1] == grp_g[0])
                    else $error("C3 mismatch");
                assert_c6_R5: assert (carry[2] == (grp_p[1] & grp_g[0]))
                    else $error("C6 mismatch");
                assert_c9_R6: assert (carry[3] == (grp_g[2] | (grp_p[1] & grp_g[0])))
                    else $error("C9 mismatch");
                assert_c12_R7: assert (carry[4] ==
                        (grp_p[3] & (grp_g[2] | (grp_p[1] & grp_g[0]))))
                    else $error("C12 mismatch");
            end
        end
    endgenerate
endmodule

// File: rtl/fixed_const_adder.sv
// Module: top of the fixed-constant adder. It adds fca_const(ONES_MASK) to a_in.
// It is purely combinational and its overall carry-in is 0.
// Each group picks an incrementer or an all-ones adder according to the mask.
module fixed_const_adder
    import fca_pkg::*;
#(
    parameter int GW = FCA_GRP_W,
    parameter int NG = FCA_NUM_GRP,
    parameter logic [NG-1:0] ONES_MASK = FCA_ONES_MASK
) (
    input  logic [GW*NG-1:0] a_in,
    output logic [GW*NG-1:0] sum_out,
    output logic             carry_out
);
    localparam int W = GW * NG;
    localparam logic CIN = 1'b0;

    logic [NG-1:0] gp;
    logic [NG-1:0] gg;
    logic [NG:0]   gc;

    // Group instances: the variant is selected by the constant field of each group.
    generate
        for (genvar k = 0; k < NG; k++) begin : g_grp
            if (ONES_MASK[k]) begin : g_dec
                fca_dec_group #(.GW(GW)) u_grp (
                    .x     (a_in[k*GW +: GW]),
                    .cin   (gc[k]),
                    .s     (sum_out[k*GW +: GW]),
                    .grp_p (gp[k]),
                    .grp_g (gg[k])
                );
            end else begin : g_inc
                fca_inc_group #(.GW(GW)) u_grp (
                    .x     (a_in[k*GW +: GW]),
                    .cin   (gc[k]),
                    .s     (sum_out[k*GW +: GW]),
                    .grp_p (gp[k]),
                    .grp_g (gg[k])
                );
            end
        end
    endgenerate

    fca_lookahead #(.NG(NG), .ONES_MASK(ONES_MASK)) u_la (
        .cin   (CIN),
        .grp_p (gp),
        .grp_g (gg),
        .carry (gc)
    );

    // Carry-out is the last lookahead carry.
    always_comb carry_out = gc[NG];

    // R1/R2: the full result matches an arithmetic reference.
    always_comb begin
        assert_sum_R1: assert (sum_out == W'(a_in + fca_const(ONES_MASK)))
            else $error("sum mismatch");
        assert_carry_R2: assert (carry_out ==
                (({1'b0, a_in} + {1'b0, fca_const(ONES_MASK)}) >> W))
            else $error("carry mismatch");
    end
endmodule

// File: tb/fixed_const_adder_tb.sv
module fixed_const_adder_tb;
    logic        clk = 1'b0;
    logic [11:0] a_in = '0;
    logic [11:0] sum_out;
    logic        carry_out;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fixed_const_adder u_dut (
        .a_in      (a_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    function automatic void chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s a=%h actual=%h expected=%h", req, a_in, act, exp);
        end
    endfunction

    // Carry recovered from a result field: (R - A - K) mod 8.
    function automatic int field_carry(int r, int a, int k);
        return (r - a - k) & 7;
    endfunction

    task automatic apply(input logic [11:0] v);
        int c3, c6, c9, c12;
        @(posedge clk);
        a_in = v;
        @(negedge clk);
        // R1 and R2 against the arithmetic reference
        chk("R1", int'(sum_out), (int'(v) + 'h1C7) & 'hFFF);
        chk("R2", int'(carry_out), ((int'(v) + 'h1C7) >> 12) & 1);
        // R4..R7: carries from reduced equations on the operand
        c3  = int'(|v[2:0]);
        c6  = c3 & int'(&v[5:3]);
        c9  = int'(|v[8:6]) | c6;
        c12 = int'(&v[11:9]) & c9;
        // R3: group rules (add 7 on fields 0 and 2, add 0 on fields 1 and 3)
        chk("R3", field_carry(int'(sum_out[2:0]), int'(v[2:0]), 7), 0);
        chk("R4", field_carry(int'(sum_out[5:3]), int'(v[5:3]), 0), c3);
        chk("R5", field_carry(int'(sum_out[8:6]), int'(v[8:6]), 7), c6);
        chk("R6", field_carry(int'(sum_out[11:9]), int'(v[11:9]), 0), c9);
        chk("R7", int'(carry_out), c12);
    endtask

    initial begin
        process::self().srandom(32'd457);
        // R8: zero input shows the carry-in is 0
        apply(12'h000);
        chk("R8", int'(sum_out), 'h1C7);
        chk("R8", int'(carry_out), 0);
        // R9: all-ones input
        apply(12'hFFF);
        chk("R9", int'(sum_out), 'h1C6);
        chk("R9", int'(carry_out), 1);
        // Directed cases that exercise the lookahead chain
        apply(12'h038);
        apply(12'hE38);
        apply(12'hE00);
        apply(12'h001);
        apply(12'hE3F);
        // Random operands drawn with a fixed seed
        for (int i = 0; i < 300; i++) apply(12'($urandom));
        // Exhaustive sweep covering R1 to R7
        for (int i = 0; i < 4096; i++) apply(12'(i));
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule